// File: doc/BRIEF.md
# Maskable Interrupt Flag and Enable Controller

This block gathers the interrupt events of a small microcontroller and turns them into one interrupt request for the core. Three event kinds are handled directly: an external interrupt pin, the overflow of the 8-bit timer, and a change on four monitored port pins. A group of four further sources is handled one level lower: a second timer, a third timer, A/D conversion completion and the capture/compare/PWM unit. Each direct source has a flag and an enable in one 8-bit control register. The peripheral group keeps its flags and enables in a separate register pair. A group enable bit in the control register gates that whole group.

Software reaches all registers over a simple register bus. It uses a write strobe, a read strobe, a 2-bit address, write data and read data that is decoded without a register stage. A global enable bit gates the request. The core clears that bit when it acknowledges an interrupt and sets it again when it returns from the handler. Vectoring and the timers are outside this block.

Top module: `irq_controller`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 at every address and `irq_req` is 0.
- R2: Address 0 is the control register. Bit 0 is the pin-change flag, bit 1 is the external-pin flag and bit 2 is the timer-overflow flag. Bits 3, 4 and 5 enable the pin-change, external-pin and timer-overflow interrupts. Bit 6 is the peripheral group enable and bit 7 is the global enable. A write stores the written value and a read returns it.
- R3: A rising edge on `ext_int_pin` passes through a two-flop synchronizer and an edge flop. It sets bit 1 on the third rising clock edge after the pin goes high. A level held high, or a falling edge, sets nothing.
- R4: A one-cycle pulse on `tmr0_ovf` sets bit 2 on the next clock edge.
- R5: The four `chg_pins` are synchronized by two flops. A read of address 3 returns {synchronized pins, 4'b0000} and copies the synchronized pins into a snapshot. While the synchronized pins differ from the snapshot, bit 0 is set on every clock edge, so the first setting edge is the third one after the pins change.
- R6: Flags are set by hardware whatever the enables hold. A software write of 0 clears a flag. A hardware set in the same cycle as a software write of 0 leaves the flag at 1.
- R7: Address 1 holds the peripheral flags and address 2 holds the peripheral enables, in bits 3:0 ordered timer-1, timer-2, A/D, CCP from bit 0. A pulse on `periph_evt[i]` sets flag i on the next edge. Bits 7:4 of both addresses read 0.
- R8: `irq_req` = bit7 AND ((bit0 AND bit3) OR (bit1 AND bit4) OR (bit2 AND bit5) OR (bit6 AND any peripheral flag whose enable is set)).
- R9: `irq_ack` clears bit 7 on the next edge, and `irq_ret` sets it. If `irq_ack` is high together with `irq_ret` or with a bus write, the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (takes the pin snapshot at address 3) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, decoded without a register stage |
| ext_int_pin | input | 1 | Asynchronous external interrupt pin |
| tmr0_ovf | input | 1 | 8-bit timer overflow pulse |
| periph_evt | input | 4 | Peripheral event pulses: timer-1, timer-2, A/D, CCP |
| chg_pins | input | 4 | Asynchronous monitored port pins 7:4 |
| irq_ack | input | 1 | Core accepted the interrupt |
| irq_ret | input | 1 | Core returned from the handler |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
On every cycle, the assertions check these local rules: each hardware event must leave its flag set on the next edge, an acknowledge must leave the global enable clear, a return must leave it set, a request must never be raised without the global enable and a pending flag, and the snapshot must follow the synchronized pins after a read. Only the bench scenarios can show the exact synchronizer latency of the pin and port-change paths. The same holds for the absence of a second flag set while a level is held. The bench also sweeps the full request equation over every control value, every peripheral flag pattern and several enable patterns, and checks the priority between acknowledge, return and bus writes.

// File: rtl/irq_pkg.sv
// Package: shared field positions, bus addresses and widths of the interrupt controller.
package irq_pkg;
    localparam int CTRL_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int NPERIPH  = 4;
    localparam int NCHG     = 4;

    localparam int B_CHG_F  = 0;
    localparam int B_INT_F  = 1;
    localparam int B_TMR_F  = 2;
    localparam int B_CHG_E  = 3;
    localparam int B_INT_E  = 4;
    localparam int B_TMR_E  = 5;
    localparam int B_GRP_E  = 6;
    localparam int B_GLB_E  = 7;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_PFLAG = 2'd1;
    localparam logic [ADDR_W-1:0] A_PEN   = 2'd2;
    localparam logic [ADDR_W-1:0] A_PORT  = 2'd3;
endpackage

// File: rtl/irq_sync_edge.sv
// Module: irq_sync_edge
// Synchronizes an asynchronous pin through STAGES flops and emits a one-cycle
// pulse on each rising edge. Assumes STAGES >= 2; reset clears the whole chain.
module irq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    // Hold the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R3
endmodule

// File: rtl/irq_pin_change.sv
// Module: irq_pin_change
// Synchronizes W port pins and compares them with a snapshot captured when
// software reads the port. Assumes snap_en is a single-cycle read strobe.
module irq_pin_change #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         snap_en,
    output logic [W-1:0] pins_sync,
    output logic         changed
);
    logic [W-1:0] stage [STAGES];
    logic [W-1:0] snap;

    // First synchronizer stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= pins;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Further synchronizer stages.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
        end
    endgenerate

    assign pins_sync = stage[STAGES-1];

    // Capture the synchronized pins when software reads the port.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap <= '0;
        else if (snap_en) snap <= pins_sync;
    end

    assign changed = |(pins_sync ^ snap);

    AST_SNAP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        snap_en |=> (snap == $past(pins_sync))); // R5
endmodule

// File: rtl/irq_core_reg.sv
// Module: irq_core_reg
// The 8-bit control register: three hardware-set flags, three enables, the
// peripheral group enable and the global enable. Hardware sets beat software
// writes; acknowledge beats return and writes on the global enable.
module irq_core_reg
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              set_chg,
    input  logic              set_int,
    input  logic              set_tmr,
    input  logic              ack,
    input  logic              ret,
    output logic [CTRL_W-1:0] ctrl
);
    logic [2:0] hw_set;
    assign hw_set = {set_tmr, set_int, set_chg};

    genvar f;
    generate
        for (f = 0; f < 3; f++) begin : g_flag
            // Flag: a hardware set wins, otherwise a write stores the data.
            always_ff @(posedge clk) begin
                if (!rst_n)         ctrl[f] <= 1'b0;
                else if (hw_set[f]) ctrl[f] <= 1'b1;
                else if (wr)        ctrl[f] <= wdata[f];
            end
        end
    endgenerate

    // Source enables and group enable: software only.
    always_ff @(posedge clk) begin
        if (!rst_n)  ctrl[B_GRP_E:B_CHG_E] <= '0;
        else if (wr) ctrl[B_GRP_E:B_CHG_E] <= wdata[B_GRP_E:B_CHG_E];
    end

    // Global enable: acknowledge clears, return sets, else software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)   ctrl[B_GLB_E] <= 1'b0;
        else if (ack) ctrl[B_GLB_E] <= 1'b0;
        else if (ret) ctrl[B_GLB_E] <= 1'b1;
        else if (wr)  ctrl[B_GLB_E] <= wdata[B_GLB_E];
    end

    AST_TMR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        set_tmr |=> ctrl[B_TMR_F]); // R4
    AST_INT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        set_int |=> ctrl[B_INT_F]); // R3
    AST_CHG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        set_chg |=> ctrl[B_CHG_F]); // R5
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !set_tmr) |=> $stable(ctrl[B_TMR_F])); // R6
    AST_ACK_CLEARS_GLB: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ctrl[B_GLB_E]); // R9
    AST_RET_SETS_GLB: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !ack) |=> ctrl[B_GLB_E]); // R9
endmodule

// File: rtl/irq_periph_reg.sv
// Module: irq_periph_reg
// Flag and enable pair for the peripheral source group. Events set flags
// whatever the enables hold; a hardware set beats a same-cycle write.
module irq_periph_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_flag,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] evt,
    output logic [N-1:0] flags,
    output logic [N-1:0] enables
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_src
            // Peripheral flag: event sets, else software writes.
            always_ff @(posedge clk) begin
                if (!rst_n)       flags[i] <= 1'b0;
                else if (evt[i])  flags[i] <= 1'b1;
                else if (wr_flag) flags[i] <= wdata[i];
            end

            AST_EVT_SETS_PFLAG: assert property (@(posedge clk) disable iff (!rst_n)
                evt[i] |=> flags[i]); // R7
        end
    endgenerate

    // Peripheral enables: software only.
    always_ff @(posedge clk) begin
        if (!rst_n)     enables <= '0;
        else if (wr_en) enables <= wdata;
    end
endmodule

// File: rtl/irq_controller.sv
// Module: irq_controller
// Top of the interrupt controller: bus decode, source conditioning, the
// control register, the peripheral register pair and the request equation.
// Assumes one bus access per cycle and single-cycle event pulses.
module irq_controller
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [CTRL_W-1:0]  bus_wdata,
    output logic [CTRL_W-1:0]  bus_rdata,
    input  logic               ext_int_pin,
    input  logic               tmr0_ovf,
    input  logic [NPERIPH-1:0] periph_evt,
    input  logic [NCHG-1:0]    chg_pins,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               irq_req
);
    localparam int PAD_P = CTRL_W - NPERIPH;
    localparam int PAD_C = CTRL_W - NCHG;

    logic               int_rise;
    logic               port_chg;
    logic [NCHG-1:0]    port_sync;
    logic [CTRL_W-1:0]  ctrl;
    logic [NPERIPH-1:0] pflags;
    logic [NPERIPH-1:0] pens;
    logic               wr_ctrl, wr_pflag, wr_pen, rd_port;
    logic               core_pend, grp_pend;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_pflag = bus_wr && (bus_addr == A_PFLAG);
    assign wr_pen   = bus_wr && (bus_addr == A_PEN);
    assign rd_port  = bus_rd && (bus_addr == A_PORT);

    irq_sync_edge #(.STAGES(2)) u_int_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_int_pin),
        .rise (int_rise)
    );

    irq_pin_change #(.W(NCHG), .STAGES(2)) u_pin_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (chg_pins),
        .snap_en  (rd_port),
        .pins_sync(port_sync),
        .changed  (port_chg)
    );

    irq_core_reg u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_ctrl),
        .wdata  (bus_wdata),
        .set_chg(port_chg),
        .set_int(int_rise),
        .set_tmr(tmr0_ovf),
        .ack    (irq_ack),
        .ret    (irq_ret),
        .ctrl   (ctrl)
    );

    irq_periph_reg #(.N(NPERIPH)) u_periph (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_flag(wr_pflag),
        .wr_en  (wr_pen),
        .wdata  (bus_wdata[NPERIPH-1:0]),
        .evt    (periph_evt),
        .flags  (pflags),
        .enables(pens)
    );

    // Read data decode.
    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl;
            A_PFLAG: bus_rdata = {{PAD_P{1'b0}}, pflags};
            A_PEN:   bus_rdata = {{PAD_P{1'b0}}, pens};
            default: bus_rdata = {port_sync, {PAD_C{1'b0}}};
        endcase
    end

    // Two-level request gating.
    always_comb begin
        core_pend = (ctrl[B_CHG_F] & ctrl[B_CHG_E])
                  | (ctrl[B_INT_F] & ctrl[B_INT_E])
                  | (ctrl[B_TMR_F] & ctrl[B_TMR_E]);
        grp_pend  = ctrl[B_GRP_E] & (|(pflags & pens));
        irq_req   = ctrl[B_GLB_E] & (core_pend | grp_pend);
    end

    AST_REQ_NEEDS_GLB: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ctrl[B_GLB_E]); // R8
    AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((|ctrl[B_TMR_F:B_CHG_F]) || (|pflags))); // R8
    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_req); // R9
endmodule

// File: tb/tb_irq_controller.sv
`timescale 1ns/100ps
module tb_irq_controller;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic       ext_int_pin, tmr0_ovf, irq_ack, irq_ret, irq_req;
    logic [3:0] periph_evt, chg_pins;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_controller dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_int_pin(ext_int_pin), .tmr0_ovf(tmr0_ovf), .periph_evt(periph_evt),
        .chg_pins(chg_pins), .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] peek_ctrl();
        return bus_rdata;
    endfunction

    task automatic step_peek(output logic [7:0] v);
        @(negedge clk);
        bus_addr = 2'd0;
        #1 v = bus_rdata;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 8'h00;
        ext_int_pin = 1'b0; tmr0_ovf = 1'b0; periph_evt = 4'h0; chg_pins = 4'h0;
        irq_ack = 1'b0; irq_ret = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1", v, 8'h00);
        end
        check("R1 irq_req", {7'b0, irq_req}, 8'h00);

        // R2 register read-back of enables
        wr(2'd0, 8'h78); rd(2'd0, v); check("R2", v, 8'h78);
        wr(2'd0, 8'h00); rd(2'd0, v); check("R2", v, 8'h00);

        // R4 timer overflow, R6 set with enables off and no request
        @(negedge clk); tmr0_ovf = 1'b1;
        @(negedge clk); tmr0_ovf = 1'b0; #1 v = bus_rdata;
        check("R4", v, 8'h04);
        check("R6 no request", {7'b0, irq_req}, 8'h00);
        wr(2'd0, 8'h00); rd(2'd0, v); check("R6 clear", v, 8'h00);
        // R6 hardware set beats same-cycle clear
        @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h00; bus_wr = 1'b1; tmr0_ovf = 1'b1;
        @(negedge clk); bus_wr = 1'b0; tmr0_ovf = 1'b0;
        rd(2'd0, v); check("R6 set wins", v, 8'h04);
        wr(2'd0, 8'h00);

        // R3 external pin latency and level behaviour
        @(negedge clk); bus_addr = 2'd0; ext_int_pin = 1'b1;
        step_peek(v); check("R3 edge1", v, 8'h00);
        step_peek(v); check("R3 edge2", v, 8'h00);
        step_peek(v); check("R3 edge3", v, 8'h02);
        wr(2'd0, 8'h00);
        repeat (5) @(negedge clk);
        #1 check("R3 level held", bus_rdata, 8'h00);
        ext_int_pin = 1'b0;
        repeat (5) @(negedge clk);
        #1 check("R3 falling", bus_rdata, 8'h00);

        // R5 pin change against snapshot
        rd(2'd3, v); check("R5 port read", v, 8'h00);
        @(negedge clk); bus_addr = 2'd0; chg_pins = 4'b0100;
        step_peek(v); check("R5 edge1", v, 8'h00);
        step_peek(v); check("R5 edge2", v, 8'h00);
        step_peek(v); check("R5 edge3", v, 8'h01);
        rd(2'd3, v); check("R5 port value", v, 8'h40);
        wr(2'd0, 8'h00);
        repeat (4) @(negedge clk);
        #1 check("R5 snapshot matched", bus_rdata, 8'h00);

        // R7 peripheral flags and enables
        for (int i = 0; i < 4; i++) begin
            wr(2'd1, 8'h00);
            @(negedge clk); periph_evt = 4'(1 << i);
            @(negedge clk); periph_evt = 4'h0;
            rd(2'd1, v); check("R7 flag", v, 8'(1 << i));
        end
        wr(2'd1, 8'hFF); rd(2'd1, v); check("R7 flag width", v, 8'h0F);
        wr(2'd2, 8'hFF); rd(2'd2, v); check("R7 enable width", v, 8'h0F);
        wr(2'd1, 8'h00);
        @(negedge clk); bus_addr = 2'd1; bus_wdata = 8'h00; bus_wr = 1'b1; periph_evt = 4'h8;
        @(negedge clk); bus_wr = 1'b0; periph_evt = 4'h0;
        rd(2'd1, v); check("R7 R6 event wins", v, 8'h08);

        // R9 global enable control
        wr(2'd0, 8'hA4); #1 check("R9 req on", {7'b0, irq_req}, 8'h01);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0; #1;
        check("R9 ack", bus_rdata, 8'h24);
        check("R9 req off", {7'b0, irq_req}, 8'h00);
        @(negedge clk); irq_ret = 1'b1;
        @(negedge clk); irq_ret = 1'b0; #1 check("R9 ret", bus_rdata, 8'hA4);
        @(negedge clk); irq_ack = 1'b1; irq_ret = 1'b1;
        @(negedge clk); irq_ack = 1'b0; irq_ret = 1'b0; #1 check("R9 ack over ret", bus_rdata, 8'h24);
        @(negedge clk); bus_addr = 2'd0; bus_wdata = 8'h80; bus_wr = 1'b1; irq_ack = 1'b1;
        @(negedge clk); bus_wr = 1'b0; irq_ack = 1'b0; #1 check("R9 ack over write", bus_rdata, 8'h00);

        // R8 request equation sweep
        for (int pe = 0; pe < 4; pe++) begin
            logic [3:0] pen;
            pen = (pe == 0) ? 4'h0 : (pe == 1) ? 4'hF : (pe == 2) ? 4'h5 : 4'hA;
            wr(2'd2, {4'h0, pen});
            for (int pf = 0; pf < 16; pf++) begin
                wr(2'd1, 8'(pf));
                for (int c = 0; c < 256; c++) begin
                    logic [7:0] cv;
                    logic exp;
                    cv = 8'(c);
                    exp = cv[7] & ((cv[0] & cv[3]) | (cv[1] & cv[4]) | (cv[2] & cv[5])
                                   | (cv[6] & (|(4'(pf) & pen))));
                    wr(2'd0, cv);
                    #1 check("R8 request", {7'b0, irq_req}, {7'b0, exp});
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule